// File: doc/BRIEF.md
# Data-Enable Timing Compliance Monitor

This block watches a data-enable strobe that is sampled on every rising edge of the pixel clock. It checks the strobe against the pulse rules of an encoded serial video mode. It measures how long each high and each low run lasts, and how many clocks separate consecutive rising edges. Any run or interval that breaks a rule sets a sticky flag. There is one flag for each kind of breach, and a synchronous clear pulse resets all of them.

Two mode inputs choose which rules apply. In sync-free operation the strobe carries no timing obligation, so nothing is ever flagged. In encoded operation minimum widths apply to both levels. When the high-frequency mode is also on, the high time and the rising-edge period must in addition be even counts of at least four clocks. The monitor observes the stream only. It never alters, corrects or delays it.

Top module: `de_timing_monitor`

## Requirements
- R1: While `sync_free` is 1 at the clock edge that samples the end of a run or a period, no flag is raised. All four flags stay 0 if `sync_free` is held at 1.
- R2: With `sync_free`=0 and `hf_mode`=0, a high run shorter than 2 clocks sets `flag_short_hi`, and a low run shorter than 2 clocks sets `flag_short_lo`. Runs of 2 or more clocks set neither flag.
- R3: With `sync_free`=0 and `hf_mode`=1, high or low runs shorter than 4 clocks set `flag_short_hi` or `flag_short_lo` respectively.
- R4: With `sync_free`=0 and `hf_mode`=1, a high run of an odd number of clocks sets `flag_odd_hi`.
- R5: With `sync_free`=0 and `hf_mode`=1, a rising-edge-to-rising-edge interval that is odd, or shorter than 4 clocks, sets `flag_odd_per`.
- R6: The first rising edge after reset only starts the period measurement and is never judged. The low run that precedes the first falling edge after reset is not judged.
- R7: Run and period counts saturate at 2^`CNT_W`-1 (1023 by default). A saturated count never triggers a parity flag and never counts as short. An odd run below saturation (for example 1021) is still flagged.
- R8: Flags are sticky. A flag stays 1 until `clr` is sampled at 1, and the flags are 0 in the cycle after that edge. When a clear and a new breach fall on the same edge, the clear wins.
- R9: A run is judged at the clock edge that samples the level change that ends it. A period is judged at the edge that samples the next rise. The flag is visible right after that edge and not before it.
- R10: After reset all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de_in | input | 1 | Data-enable strobe under test |
| sync_free | input | 1 | 1 selects sync-free operation (no rules) |
| hf_mode | input | 1 | 1 selects the high-frequency rule set |
| clr | input | 1 | Synchronous clear of all flags |
| flag_short_hi | output | 1 | Sticky: high run below minimum |
| flag_short_lo | output | 1 | Sticky: low run below minimum |
| flag_odd_hi | output | 1 | Sticky: odd high run in high-frequency mode |
| flag_odd_per | output | 1 | Sticky: odd or too short rising-edge period |

## Verification
Every flag is registered once. A breach therefore shows up just after the clock edge that samples the ending level change of `de_in`, one edge after the level change is driven. The bench drives all inputs on falling edges, so a result is read at the falling edge half a cycle after the deciding rising edge. A dedicated check samples the flag on both sides of that edge. The parameter sweeps read the flags only after several trailing low cycles, once every judged edge has been sampled. The clear tests read the flags one edge after `clr` is sampled.

// File: rtl/de_timing_monitor.sv
module de_timing_monitor #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de_in,
  input  logic sync_free,
  input  logic hf_mode,
  input  logic clr,
  output logic flag_short_hi,
  output logic flag_short_lo,
  output logic flag_odd_hi,
  output logic flag_odd_per
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] MIN_NORM = CNT_W'(2);
  localparam logic [CNT_W-1:0] MIN_HF   = CNT_W'(4);

  logic             de_q, seen_rise, seen_fall;
  logic [CNT_W-1:0] run_cnt, per_cnt;

  wire rise    = de_in & ~de_q;
  wire fall    = ~de_in & de_q;
  wire enc     = ~sync_free;
  wire run_sat = (run_cnt == CNT_MAX);
  wire per_sat = (per_cnt == CNT_MAX);
  wire [CNT_W-1:0] min_len = hf_mode ? MIN_HF : MIN_NORM;

  wire ev_short_hi = enc & fall & ~run_sat & (run_cnt < min_len);
  wire ev_short_lo = enc & rise & seen_fall & ~run_sat & (run_cnt < min_len);
  wire ev_odd_hi   = enc & hf_mode & fall & ~run_sat & run_cnt[0];
  wire ev_odd_per  = enc & hf_mode & rise & seen_rise & ~per_sat
                   & (per_cnt[0] | (per_cnt < MIN_HF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q      <= 1'b0;
      seen_rise <= 1'b0;
      seen_fall <= 1'b0;
      run_cnt   <= '0;
      per_cnt   <= '0;
    end else begin
      de_q <= de_in;
      if (rise) seen_rise <= 1'b1;
      if (fall) seen_fall <= 1'b1;
      if (rise || fall) run_cnt <= CNT_W'(1);
      else if (!run_sat) run_cnt <= run_cnt + 1'b1;
      if (rise) per_cnt <= CNT_W'(1);
      else if (!per_sat) per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      flag_short_hi <= 1'b0;
      flag_short_lo <= 1'b0;
      flag_odd_hi   <= 1'b0;
      flag_odd_per  <= 1'b0;
    end else begin
      flag_short_hi <= flag_short_hi | ev_short_hi;
      flag_short_lo <= flag_short_lo | ev_short_lo;
      flag_odd_hi   <= flag_odd_hi   | ev_odd_hi;
      flag_odd_per  <= flag_odd_per  | ev_odd_per;
    end
  end
endmodule

module de_timing_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic de_in,
  input logic sync_free,
  input logic hf_mode,
  input logic clr,
  input logic flag_short_hi,
  input logic flag_short_lo,
  input logic flag_odd_hi,
  input logic flag_odd_per
);
  logic [3:0] flags;
  logic [1:0] age;
  logic       d1, d2;
  assign flags = {flag_short_hi, flag_short_lo, flag_odd_hi, flag_odd_per};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0; d1 <= 1'b0; d2 <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      d1 <= de_in;
      d2 <= d1;
    end
  end

  p_sync_free_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_free && flags == 4'b0) |=> flags == 4'b0);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> flags == 4'b0);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  p_one_clock_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !de_in && d1 && !d2 && !sync_free && !hf_mode && !clr)
      |=> flag_short_hi);

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> flags == 4'b0);
endmodule

bind de_timing_monitor de_timing_monitor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .de_in(de_in), .sync_free(sync_free),
  .hf_mode(hf_mode), .clr(clr), .flag_short_hi(flag_short_hi),
  .flag_short_lo(flag_short_lo), .flag_odd_hi(flag_odd_hi),
  .flag_odd_per(flag_odd_per)
);

// File: tb/test_de_timing_monitor.sv
module test_de_timing_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0, de_in = 1'b0, sync_free = 1'b0, hf_mode = 1'b0, clr = 1'b0;
  logic flag_short_hi, flag_short_lo, flag_odd_hi, flag_odd_per;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  de_timing_monitor i_de_timing_monitor (
    .clk(clk), .rst_n(rst_n), .de_in(de_in), .sync_free(sync_free),
    .hf_mode(hf_mode), .clr(clr), .flag_short_hi(flag_short_hi),
    .flag_short_lo(flag_short_lo), .flag_odd_hi(flag_odd_hi),
    .flag_odd_per(flag_odd_per)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [3:0] exp);
    checks++;
    if ({flag_short_hi, flag_short_lo, flag_odd_hi, flag_odd_per} !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag,
               {flag_short_hi, flag_short_lo, flag_odd_hi, flag_odd_per}, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      de_in = v;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; de_in = 1'b0; clr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] exp;
    int mn;
    do_reset();
    @(negedge clk);
    check_all("R10 reset state", 4'b0000);

    // R1..R6: sweep of high and low lengths over all mode combinations
    for (int mode = 0; mode < 3; mode++) begin
      for (int h = 1; h <= 7; h++) begin
        for (int l = 1; l <= 7; l++) begin
          sync_free = (mode == 0);
          hf_mode   = (mode == 2);
          do_reset();
          hold(1'b0, 1);            // R6: initial low is too short but unjudged
          for (int p = 0; p < 3; p++) begin
            hold(1'b1, h);
            hold(1'b0, (p == 2) ? 8 : l);
          end
          mn = hf_mode ? 4 : 2;
          exp[3] = (h < mn);
          exp[2] = (l < mn);
          exp[1] = hf_mode && (h % 2 == 1);
          exp[0] = hf_mode && (((h + l) % 2 == 1) || (h + l) < 4);
          if (sync_free) exp = 4'b0000;
          check_all($sformatf("R1/R2/R3/R4/R5/R6 mode=%0d h=%0d l=%0d", mode, h, l), exp);
        end
      end
    end

    // R9: flag appears right after the edge that samples the fall
    sync_free = 1'b0; hf_mode = 1'b0;
    do_reset();
    hold(1'b0, 3);
    hold(1'b1, 1);
    @(negedge clk); de_in = 1'b0;
    check("R9 before sampling edge", flag_short_hi, 1'b0);
    @(negedge clk);
    check("R9 after sampling edge", flag_short_hi, 1'b1);

    // R8: sticky across good pulses, then cleared
    hold(1'b0, 3);
    hold(1'b1, 5); hold(1'b0, 5);
    check("R8 sticky", flag_short_hi, 1'b1);
    pulse_clr();
    check_all("R8 clear", 4'b0000);

    // R8: clear wins over a simultaneous breach
    hold(1'b1, 1);
    @(negedge clk); de_in = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R8 clear beats breach", flag_short_hi, 1'b0);

    // R7: saturated runs and periods are exempt
    hf_mode = 1'b1;
    do_reset();
    hold(1'b0, 2);
    hold(1'b1, 1100); hold(1'b0, 4);
    hold(1'b1, 4); hold(1'b0, 6);
    check_all("R7 saturated exempt", 4'b0000);

    // R7: odd run below saturation still flagged
    do_reset();
    hold(1'b0, 2);
    hold(1'b1, 1021); hold(1'b0, 4);
    check("R7 odd below saturation", flag_odd_hi, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule